// File: doc/BRIEF.md
# Exception and Interrupt Entry Sequencer

This block decides, in each cycle, whether the processor enters a handler for a synchronous exception or for an external interrupt. When an event is accepted, it saves the caller's context, sets the privileged, blocked and alternate-bank bits of the status word and selects the handler address from the event class. All of this is committed on one clock edge.

The core presents its live status word, program counter, stack register R15, vector base and its sleep and delay-slot state alongside the event inputs. The block drives the current interrupt mask level (status bits 7:4) to an external interrupt controller. The controller answers with a vector or with "none". After the committing edge, `taken_o` pulses for one cycle, and the core uses that pulse to clear its sleep and delay-slot flags. The block keeps the status, saved-status, saved-PC, saved-R15, exception-code, interrupt-code and PC registers.

Top module: `excseq_entry`

## Requirements
- R1: When an exception and an interrupt request arrive in the same cycle, the exception is taken: `expevt_o` gets its code and `intevt_o` is left unchanged.
- R2: While status bit 28 (block bit) of `sr_i` is set, any exception code other than 0x1E0 is replaced by 0x000 and handled as a reset-class entry. Code 0x1E0 keeps its code and its normal vector.
- R3: While the block bit is set, an interrupt request is ignored unless `sleep_i` is high. An ignored request gives no `taken_o` and no register change. While the core is sleeping, the request is taken.
- R4: On an accepted event, `ssr_o` gets `sr_i` and `sgr_o` gets `r15_i`. The new status word is `sr_i` with bits 28 (block), 29 (bank) and 30 (privileged) set.
- R5: When `dslot_i` is high, the saved PC is `pc_i` minus 2. Otherwise it is `pc_i`.
- R6: Exception codes 0x000, 0x020 and 0x140 set PC to 0xA0000000, clear status bit 15 (FPU disable) and force status bits 7:4 to 0xF.
- R7: Exception codes 0x040 and 0x060 set PC to `vbr_i` + 0x400.
- R8: Exception code 0x160 adds 2 to the saved PC, after any delay-slot rewind. It and every other exception code not listed in R6 or R7 set PC to `vbr_i` + 0x100.
- R9: `irq_mask_o` always equals `sr_i[7:4]`. An interrupt whose controller answer has `irq_vec_vld_i` low is not taken. Otherwise `intevt_o` gets `irq_vec_i` and PC becomes `vbr_i` + 0x600.
- R10: Every accepted exception writes its effective code into `expevt_o`.
- R11: All register outputs change only on the edge that commits an entry. `taken_o` is high for exactly the cycle after that edge.
- R12: Reset sets `sr_o` to 0x50000000 (block and privileged bits set) and `pc_o` to 0xA0000000. All other registers are cleared and `taken_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| exc_vld_i | input | 1 | A synchronous exception is pending |
| exc_code_i | input | 12 | Code of the pending exception |
| irq_req_i | input | 1 | External interrupt request |
| irq_mask_o | output | 4 | Mask level presented to the interrupt controller |
| irq_vec_vld_i | input | 1 | Controller has an unmasked vector |
| irq_vec_i | input | 12 | Interrupt vector code from the controller |
| sr_i | input | 32 | Live status word |
| pc_i | input | 32 | PC of the interrupted instruction |
| r15_i | input | 32 | Live stack register |
| vbr_i | input | 32 | Vector base |
| sleep_i | input | 1 | Core is in sleep state |
| dslot_i | input | 1 | Event instruction sits in a delay slot |
| taken_o | output | 1 | One-cycle pulse after an entry commits |
| sr_o | output | 32 | Status word register |
| ssr_o | output | 32 | Saved status register |
| spc_o | output | 32 | Saved PC register |
| sgr_o | output | 32 | Saved R15 register |
| expevt_o | output | 12 | Last exception code |
| intevt_o | output | 12 | Last interrupt code |
| pc_o | output | 32 | Handler PC register |

## Verification
The bench goes after the masking corner cases. A blocked exception that is not promoted would show its own code in `expevt_o` instead of 0x000. A wrongly exempted code 0x1E0 would land on the reset address. A blocked interrupt taken while the core is awake would raise `taken_o`. It also combines the delay-slot rewind with the trap advance and checks the FD clear and the mask force on reset-class codes. Either fault would show as a wrong `spc_o` or `sr_o`. A concurrent exception and interrupt must leave `intevt_o` unchanged, and a "none" answer from the controller must leave every register as it was.

// File: rtl/excseq_pkg.sv
package excseq_pkg;
  parameter int XLEN     = 32;
  parameter int CODE_W   = 12;
  parameter int IMASK_W  = 4;

  localparam int SR_BL_BIT  = 28;
  localparam int SR_RB_BIT  = 29;
  localparam int SR_MD_BIT  = 30;
  localparam int SR_FD_BIT  = 15;
  localparam int IMASK_LSB  = 4;

  localparam logic [XLEN-1:0] RESET_PC  = 32'hA000_0000;
  localparam logic [XLEN-1:0] SR_RESET  = 32'h5000_0000;
  localparam logic [XLEN-1:0] OFS_GEN   = 32'h0000_0100;
  localparam logic [XLEN-1:0] OFS_MISS  = 32'h0000_0400;
  localparam logic [XLEN-1:0] OFS_IRQ   = 32'h0000_0600;

  localparam logic [CODE_W-1:0] CODE_RESET = 12'h000;
  localparam logic [CODE_W-1:0] CODE_TRAP  = 12'h160;
  localparam logic [CODE_W-1:0] CODE_KEEP  = 12'h1E0;

  localparam int N_RST_CODES  = 3;
  localparam int N_MISS_CODES = 2;
  localparam logic [N_RST_CODES*CODE_W-1:0]  RST_CODES  = {12'h140, 12'h020, 12'h000};
  localparam logic [N_MISS_CODES*CODE_W-1:0] MISS_CODES = {12'h060, 12'h040};

  typedef enum logic [1:0] {
    CLS_NONE = 2'd0,
    CLS_EXC  = 2'd1,
    CLS_IRQ  = 2'd2
  } evt_cls_e;
endpackage

// File: rtl/excseq_arbiter.sv
module excseq_arbiter
  import excseq_pkg::*;
#(
  parameter int CW = CODE_W
) (
  input  logic          exc_vld_i,
  input  logic [CW-1:0] exc_code_i,
  input  logic          irq_req_i,
  input  logic          irq_vec_vld_i,
  input  logic          bl_i,
  input  logic          sleep_i,
  output evt_cls_e      cls_o,
  output logic [CW-1:0] code_o
);
  logic irq_ok;

  // blocked irq only wakes a sleeping core; controller "none" aborts
  assign irq_ok = irq_req_i & ~exc_vld_i & (~bl_i | sleep_i) & irq_vec_vld_i;

  always_comb begin
    code_o = exc_code_i;
    if (bl_i && (exc_code_i != CW'(CODE_KEEP))) code_o = CW'(CODE_RESET);
  end

  always_comb begin
    if (exc_vld_i)   cls_o = CLS_EXC;
    else if (irq_ok) cls_o = CLS_IRQ;
    else             cls_o = CLS_NONE;
  end
endmodule

// File: rtl/excseq_vector.sv
module excseq_vector
  import excseq_pkg::*;
#(
  parameter int XW = XLEN,
  parameter int CW = CODE_W,
  parameter int MW = IMASK_W
) (
  input  evt_cls_e      cls_i,
  input  logic [CW-1:0] code_i,
  input  logic [XW-1:0] vbr_i,
  input  logic [XW-1:0] sr_i,
  output logic [XW-1:0] pc_o,
  output logic [XW-1:0] sr_o,
  output logic          trap_o
);
  logic [N_RST_CODES-1:0]  rst_hit;
  logic [N_MISS_CODES-1:0] miss_hit;
  logic is_rst, is_miss;

  for (genvar g = 0; g < N_RST_CODES; g++) begin : g_rst
    assign rst_hit[g] = (code_i == CW'(RST_CODES[g*CODE_W +: CODE_W]));
  end
  for (genvar g = 0; g < N_MISS_CODES; g++) begin : g_miss
    assign miss_hit[g] = (code_i == CW'(MISS_CODES[g*CODE_W +: CODE_W]));
  end

  assign is_rst  = |rst_hit;
  assign is_miss = |miss_hit;

  always_comb begin
    sr_o = sr_i;
    sr_o[SR_BL_BIT] = 1'b1;
    sr_o[SR_RB_BIT] = 1'b1;
    sr_o[SR_MD_BIT] = 1'b1;
    pc_o   = vbr_i + XW'(OFS_GEN);
    trap_o = 1'b0;
    unique case (cls_i)
      CLS_EXC: begin
        if (is_rst) begin
          sr_o[SR_FD_BIT] = 1'b0;
          sr_o[IMASK_LSB +: MW] = '1;
          pc_o = XW'(RESET_PC);
        end else if (is_miss) begin
          pc_o = vbr_i + XW'(OFS_MISS);
        end else begin
          trap_o = (code_i == CW'(CODE_TRAP));
        end
      end
      CLS_IRQ: pc_o = vbr_i + XW'(OFS_IRQ);
      default: ;
    endcase
  end
endmodule

// File: rtl/excseq_save.sv
module excseq_save
  import excseq_pkg::*;
#(
  parameter int XW         = XLEN,
  parameter int INSN_BYTES = 2
) (
  input  logic [XW-1:0] pc_i,
  input  logic          dslot_i,
  input  logic          trap_i,
  output logic [XW-1:0] spc_o
);
  localparam logic [XW-1:0] STEP = XW'(INSN_BYTES);
  logic [XW-1:0] rewound;

  // rewind so the branch re-executes; trap resumes after itself
  assign rewound = dslot_i ? (pc_i - STEP) : pc_i;
  assign spc_o   = trap_i ? (rewound + STEP) : rewound;
endmodule

// File: rtl/excseq_entry.sv
module excseq_entry
  import excseq_pkg::*;
#(
  parameter int XW = XLEN,
  parameter int CW = CODE_W,
  parameter int MW = IMASK_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          exc_vld_i,
  input  logic [CW-1:0] exc_code_i,
  input  logic          irq_req_i,
  output logic [MW-1:0] irq_mask_o,
  input  logic          irq_vec_vld_i,
  input  logic [CW-1:0] irq_vec_i,
  input  logic [XW-1:0] sr_i,
  input  logic [XW-1:0] pc_i,
  input  logic [XW-1:0] r15_i,
  input  logic [XW-1:0] vbr_i,
  input  logic          sleep_i,
  input  logic          dslot_i,
  output logic          taken_o,
  output logic [XW-1:0] sr_o,
  output logic [XW-1:0] ssr_o,
  output logic [XW-1:0] spc_o,
  output logic [XW-1:0] sgr_o,
  output logic [CW-1:0] expevt_o,
  output logic [CW-1:0] intevt_o,
  output logic [XW-1:0] pc_o
);
  evt_cls_e      cls;
  logic [CW-1:0] code_eff;
  logic [XW-1:0] pc_new, sr_new, spc_new;
  logic          trap;

  assign irq_mask_o = sr_i[IMASK_LSB +: MW];

  excseq_arbiter #(.CW(CW)) u_arb (
    .exc_vld_i     (exc_vld_i),
    .exc_code_i    (exc_code_i),
    .irq_req_i     (irq_req_i),
    .irq_vec_vld_i (irq_vec_vld_i),
    .bl_i          (sr_i[SR_BL_BIT]),
    .sleep_i       (sleep_i),
    .cls_o         (cls),
    .code_o        (code_eff)
  );

  excseq_vector #(.XW(XW), .CW(CW), .MW(MW)) u_vec (
    .cls_i  (cls),
    .code_i (code_eff),
    .vbr_i  (vbr_i),
    .sr_i   (sr_i),
    .pc_o   (pc_new),
    .sr_o   (sr_new),
    .trap_o (trap)
  );

  excseq_save #(.XW(XW)) u_save (
    .pc_i    (pc_i),
    .dslot_i (dslot_i),
    .trap_i  (trap),
    .spc_o   (spc_new)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      taken_o  <= 1'b0;
      sr_o     <= XW'(SR_RESET);
      ssr_o    <= '0;
      spc_o    <= '0;
      sgr_o    <= '0;
      expevt_o <= '0;
      intevt_o <= '0;
      pc_o     <= XW'(RESET_PC);
    end else begin
      taken_o <= (cls != CLS_NONE);
      if (cls != CLS_NONE) begin
        sr_o  <= sr_new;
        ssr_o <= sr_i;
        spc_o <= spc_new;
        sgr_o <= r15_i;
        pc_o  <= pc_new;
        if (cls == CLS_EXC) expevt_o <= code_eff;
        else                intevt_o <= irq_vec_i;
      end
    end
  end
endmodule

// File: rtl/excseq_entry_chk.sv
module excseq_entry_chk
  import excseq_pkg::*;
(
  input logic            clk_i,
  input logic            rst_ni,
  input logic            exc_vld_i,
  input logic            irq_req_i,
  input logic            irq_vec_vld_i,
  input logic            sleep_i,
  input logic [XLEN-1:0] sr_i,
  input logic            taken_o,
  input logic [XLEN-1:0] sr_o,
  input logic [XLEN-1:0] ssr_o,
  input logic [XLEN-1:0] pc_o
);
  // R1
  exc_always_taken_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_vld_i |=> taken_o);

  // R3
  blocked_irq_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_req_i && !exc_vld_i && sr_i[SR_BL_BIT] && !sleep_i) |=> !taken_o);

  // R9
  irq_none_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_req_i && !exc_vld_i && !irq_vec_vld_i) |=> !taken_o);

  // R4
  entry_bits_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    taken_o |-> (sr_o[SR_BL_BIT] && sr_o[SR_RB_BIT] && sr_o[SR_MD_BIT]));

  // R11
  hold_when_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !taken_o |-> ($stable(sr_o) && $stable(ssr_o) && $stable(pc_o)));
endmodule

bind excseq_entry excseq_entry_chk u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .exc_vld_i     (exc_vld_i),
  .irq_req_i     (irq_req_i),
  .irq_vec_vld_i (irq_vec_vld_i),
  .sleep_i       (sleep_i),
  .sr_i          (sr_i),
  .taken_o       (taken_o),
  .sr_o          (sr_o),
  .ssr_o         (ssr_o),
  .pc_o          (pc_o)
);

// File: tb/tb_excseq_entry.sv
`timescale 1ns/1ps
module tb_excseq_entry;
  localparam logic [31:0] VBR = 32'h8C00_0000;

  typedef struct packed {
    logic        taken;
    logic [31:0] sr, ssr, spc, sgr, pc;
    logic [11:0] expevt, intevt;
  } exp_t;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic exc_vld_i = 0, irq_req_i = 0, irq_vec_vld_i = 0, sleep_i = 0, dslot_i = 0;
  logic [11:0] exc_code_i = '0, irq_vec_i = '0;
  logic [31:0] sr_i = '0, pc_i = '0, r15_i = '0, vbr_i = VBR;
  logic [3:0]  irq_mask_o;
  logic        taken_o;
  logic [31:0] sr_o, ssr_o, spc_o, sgr_o, pc_o;
  logic [11:0] expevt_o, intevt_o;

  int total = 0, bad = 0;
  exp_t  q_exp[$];
  string q_req[$];
  exp_t  m;

  always #2 clk = ~clk;

  excseq_entry dut (
    .clk_i(clk), .rst_ni(rst_ni), .exc_vld_i(exc_vld_i), .exc_code_i(exc_code_i),
    .irq_req_i(irq_req_i), .irq_mask_o(irq_mask_o), .irq_vec_vld_i(irq_vec_vld_i),
    .irq_vec_i(irq_vec_i), .sr_i(sr_i), .pc_i(pc_i), .r15_i(r15_i), .vbr_i(vbr_i),
    .sleep_i(sleep_i), .dslot_i(dslot_i), .taken_o(taken_o), .sr_o(sr_o),
    .ssr_o(ssr_o), .spc_o(spc_o), .sgr_o(sgr_o), .expevt_o(expevt_o),
    .intevt_o(intevt_o), .pc_o(pc_o)
  );

  task automatic cmp(string req, string name, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, name, act, exp);
    end
  endtask

  // monitor: compare one expected item per committing edge
  always @(posedge clk) begin
    #1;
    if (q_exp.size() > 0) begin
      exp_t  e;
      string r;
      e = q_exp.pop_front();
      r = q_req.pop_front();
      cmp(r, "taken",  {31'b0, taken_o}, {31'b0, e.taken});
      cmp(r, "sr",     sr_o,  e.sr);
      cmp(r, "ssr",    ssr_o, e.ssr);
      cmp(r, "spc",    spc_o, e.spc);
      cmp(r, "sgr",    sgr_o, e.sgr);
      cmp(r, "pc",     pc_o,  e.pc);
      cmp(r, "expevt", {20'b0, expevt_o}, {20'b0, e.expevt});
      cmp(r, "intevt", {20'b0, intevt_o}, {20'b0, e.intevt});
    end
  end

  // driver: apply one event cycle, predict, push
  task automatic drive(string req, logic ev, logic [11:0] code, logic irq, logic vv,
                       logic [11:0] vec, logic [31:0] sr, logic [31:0] pc,
                       logic [31:0] r15, logic slp, logic ds);
    logic do_irq, take;
    logic [11:0] c;
    @(negedge clk);
    exc_vld_i = ev; exc_code_i = code; irq_req_i = irq; irq_vec_vld_i = vv;
    irq_vec_i = vec; sr_i = sr; pc_i = pc; r15_i = r15; sleep_i = slp; dslot_i = ds;
    do_irq = irq && !ev;
    c = code;
    if (sr[28] && ev && code != 12'h1E0) c = 12'h000;
    take = ev || (do_irq && (!sr[28] || slp) && vv);
    m.taken = take;
    if (take) begin
      m.sr  = sr | 32'h7000_0000;
      m.ssr = sr;
      m.sgr = r15;
      m.spc = ds ? pc - 32'd2 : pc;
      if (ev) begin
        m.expevt = c;
        if (c == 12'h000 || c == 12'h020 || c == 12'h140) begin
          m.sr[15] = 1'b0; m.sr[7:4] = 4'hF; m.pc = 32'hA000_0000;
        end else if (c == 12'h040 || c == 12'h060) begin
          m.pc = VBR + 32'h400;
        end else begin
          if (c == 12'h160) m.spc = m.spc + 32'd2;
          m.pc = VBR + 32'h100;
        end
      end else begin
        m.intevt = vec;
        m.pc = VBR + 32'h600;
      end
    end
    q_exp.push_back(m);
    q_req.push_back(req);
    #1;
    cmp("R9", "irq_mask", {28'b0, irq_mask_o}, {28'b0, sr[7:4]});
    @(negedge clk);
    exc_vld_i = 0; irq_req_i = 0; irq_vec_vld_i = 0; sleep_i = 0; dslot_i = 0;
  endtask

  initial begin
    #400000;
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    #1;
    // R12 reset state
    cmp("R12", "taken", {31'b0, taken_o}, 32'd0);
    cmp("R12", "sr", sr_o, 32'h5000_0000);
    cmp("R12", "pc", pc_o, 32'hA000_0000);
    cmp("R12", "ssr", ssr_o, 32'd0);
    cmp("R12", "expevt", {20'b0, expevt_o}, 32'd0);
    m = '0;
    m.sr = 32'h5000_0000;
    m.pc = 32'hA000_0000;

    drive("R11_idle", 0, 12'h0, 0, 0, 12'h0, 32'h0000_00F0, 32'h100, 32'h1, 0, 0);
    drive("R4_R10_gen", 1, 12'h180, 0, 0, 12'h0, 32'h0000_00F0, 32'h1000, 32'h5555, 0, 0);
    drive("R7_miss40", 1, 12'h040, 0, 0, 12'h0, 32'h0000_0030, 32'h1100, 32'h6, 0, 0);
    drive("R7_miss60", 1, 12'h060, 0, 0, 12'h0, 32'h0000_0030, 32'h1200, 32'h7, 0, 0);
    drive("R8_trap", 1, 12'h160, 0, 0, 12'h0, 32'h0000_0000, 32'h1300, 32'h8, 0, 0);
    drive("R5_dslot", 1, 12'h0E0, 0, 0, 12'h0, 32'h0000_0000, 32'h2002, 32'h9, 0, 1);
    drive("R5_R8_dslot_trap", 1, 12'h160, 0, 0, 12'h0, 32'h0000_0000, 32'h2402, 32'hA, 0, 1);
    drive("R6_code020", 1, 12'h020, 0, 0, 12'h0, 32'h0000_8030, 32'h3000, 32'hB, 0, 0);
    drive("R6_code140", 1, 12'h140, 0, 0, 12'h0, 32'h0000_8000, 32'h3100, 32'hC, 0, 0);
    drive("R1_exc_over_irq", 1, 12'h180, 1, 1, 12'h3A0, 32'h0000_0000, 32'h3200, 32'hD, 0, 0);
    drive("R2_promote", 1, 12'h0A0, 0, 0, 12'h0, 32'h1000_8020, 32'h3300, 32'hE, 0, 0);
    drive("R2_keep1e0", 1, 12'h1E0, 0, 0, 12'h0, 32'h1000_0020, 32'h3400, 32'hF, 0, 0);
    drive("R3_blocked_awake", 0, 12'h0, 1, 1, 12'h200, 32'h1000_0050, 32'h3500, 32'h10, 0, 0);
    drive("R3_blocked_sleep", 0, 12'h0, 1, 1, 12'h220, 32'h1000_0050, 32'h3600, 32'h11, 1, 0);
    drive("R9_none", 0, 12'h0, 1, 0, 12'h240, 32'h0000_00A0, 32'h3700, 32'h12, 0, 0);
    drive("R9_irq", 0, 12'h0, 1, 1, 12'h320, 32'h0000_00A0, 32'h3800, 32'h13, 0, 0);
    drive("R11_idle2", 0, 12'h0, 0, 1, 12'h0, 32'h0000_0000, 32'h3900, 32'h14, 1, 1);
    repeat (3) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule